// File: doc/BRIEF.md
# Compare-Match Conversion Trigger

This block pairs a 16-bit period timer with a compare register and a small conversion sequencer. When the compare-mode field selects the event-trigger code, a match between the timer and the compare value has two effects. It restarts the timer at zero, and it asks the converter to start by raising its busy flag. The timer therefore sets the sampling period, and acquisition followed by conversion repeats with no software action.

Once started, the sequencer waits for a programmable acquisition time. It then runs a fixed-length conversion and latches the supplied sample value. At the end it drops busy and raises a sticky done flag. Software can also start a conversion directly with a start pulse.

The analog path is not modelled. The sample arrives on an input and is read back as a high/low byte pair, which can be right or left justified.

Top module: `cmp_adc_trigger`

## Requirements
- R1: After reset the timer reads 0, busy and done read 0, and both result bytes read 0.
- R2: Each cycle with `tmr_tick` high and no event match, the timer adds one, wrapping from 16'hFFFF to 0. With `tmr_tick` low it holds its value.
- R3: An event match needs three things in the same cycle: `tmr_tick` high, `cmp_mode` equal to 4'b1011, and the timer equal to `cmp_value`. On a match `special_trig` is high in that cycle and the timer reads 0 on the next cycle.
- R4: With any other `cmp_mode` value, the timer counts past `cmp_value`, `special_trig` stays low and no conversion starts.
- R5: A match while `adc_enable` is 1 and busy is 0 sets busy on the next cycle.
- R6: A match while `adc_enable` is 0 leaves busy at 0, but it still clears the timer.
- R7: A match while busy is 1 does not restart or lengthen the running conversion, but it still clears the timer.
- R8: Busy stays high for (A + 11) × TAD_CYCLES clock cycles, where TAD_CYCLES defaults to 2. A is taken from `acq_code` when the conversion starts: codes 0 to 7 give 0, 2, 4, 6, 8, 12, 16 and 20.
- R9: On the edge where busy falls, done becomes 1 and the result takes the `sample_in` value present in the last busy cycle.
- R10: Done stays at 1 until `done_clr` is pulsed. If a conversion ends in the same cycle as `done_clr`, done ends at 1.
- R11: A `sw_start` pulse starts a conversion just as a match does, but only when `adc_enable` is 1 and busy is 0. Otherwise it is ignored.
- R12: With `left_just` = 0, `result_hi` is {6'b0, r[9:8]} and `result_lo` is r[7:0]. With `left_just` = 1, `result_hi` is r[9:2] and `result_lo` is {r[1:0], 6'b0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | Timer increment enable |
| cmp_mode | input | 4 | Compare mode; 4'b1011 selects the event trigger |
| cmp_value | input | 16 | Compare value |
| adc_enable | input | 1 | Converter enable |
| acq_code | input | 3 | Acquisition time code |
| left_just | input | 1 | Result justification select |
| sw_start | input | 1 | Software start pulse |
| done_clr | input | 1 | Clear pulse for the done flag |
| sample_in | input | 10 | Sample value returned by the conversion stub |
| timer_q | output | 16 | Timer count |
| special_trig | output | 1 | Event-match pulse |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky done flag |
| result_hi | output | 8 | Result high byte |
| result_lo | output | 8 | Result low byte |

## Verification
The hardest situation to reach is a match that lands while a conversion is still running, including on the very edge where it ends. That match must reset the timer and must leave the conversion alone. The directed part sets a compare period of 6 cycles against a 22-cycle conversion, so several matches fall inside each conversion. The random part draws compare values, tick density and acquisition codes so that matches land at every phase of the acquisition and conversion counters. A per-cycle reference model checks every output throughout.

// File: rtl/cat_pkg.sv
package cat_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ACQ  = 2'd1,
      SEQ_CONV = 2'd2
   } seq_state_e;

   localparam int unsigned ACQ_MAX_PERIODS = 20;

   // acquisition periods: doubles up to code 4, then steps by 4
   function automatic int unsigned acq_periods(input logic [2:0] code);
      int unsigned c;
      c = int'(code);
      if (c <= 4) return 2 * c;
      return 8 + 4 * (c - 4);
   endfunction

endpackage

// File: rtl/cat_timer.sv
module cat_timer #(
   parameter int TMR_W            = 16,
   parameter int MODE_W           = 4,
   parameter logic [3:0] SEV_CODE = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [MODE_W-1:0] mode,
   input  logic [TMR_W-1:0]  cmp,
   output logic [TMR_W-1:0]  count,
   output logic              match
);

   if (MODE_W != 4) begin : g_bad_mode
      $error("cat_timer: MODE_W must be 4");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("cat_timer: TMR_W too small");
   end

   logic mode_sel;

   always_comb begin
      mode_sel = (mode == SEV_CODE);
      match    = tick && mode_sel && (count == cmp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (match) count <= '0;
      else if (tick)  count <= count + 1'b1;
   end

endmodule

// File: rtl/cat_sequencer.sv
module cat_sequencer
   import cat_pkg::*;
#(
   parameter int ACQ_W        = 3,
   parameter int RES_W        = 10,
   parameter int CONV_PERIODS = 11,
   parameter int TAD_CYCLES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             enable,
   input  logic [ACQ_W-1:0] acq_code,
   input  logic [RES_W-1:0] sample_in,
   input  logic             done_clr,
   output logic             busy,
   output logic             done_flag,
   output logic [RES_W-1:0] result
);

   localparam int LONGEST = (int'(ACQ_MAX_PERIODS) > CONV_PERIODS) ?
                            int'(ACQ_MAX_PERIODS) : CONV_PERIODS;
   localparam int CNT_MAX = LONGEST * TAD_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   if (ACQ_W != 3) begin : g_bad_acq
      $error("cat_sequencer: ACQ_W must be 3");
   end
   if (CONV_PERIODS < 1 || TAD_CYCLES < 1) begin : g_bad_len
      $error("cat_sequencer: period counts must be positive");
   end

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] acq_cycles;
   logic [CNT_W-1:0] conv_load;
   logic             accept;
   logic             finish;

   // the tad scaling is a shift-free multiply when one clock per period
   if (TAD_CYCLES == 1) begin : g_tad_one
      always_comb acq_cycles = CNT_W'(acq_periods(acq_code));
   end else begin : g_tad_mul
      always_comb acq_cycles = CNT_W'(acq_periods(acq_code) * TAD_CYCLES);
   end

   always_comb begin
      conv_load = CNT_W'(CONV_PERIODS * TAD_CYCLES - 1);
      accept    = start_req && enable && (state == SEQ_IDLE);
      finish    = (state == SEQ_CONV) && (cnt == '0);
      busy      = (state != SEQ_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         cnt    <= '0;
         result <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  if (acq_cycles == '0) begin
                     state <= SEQ_CONV;
                     cnt   <= conv_load;
                  end else begin
                     state <= SEQ_ACQ;
                     cnt   <= acq_cycles - 1'b1;
                  end
               end
            end
            SEQ_ACQ: begin
               if (cnt == '0) begin
                  state <= SEQ_CONV;
                  cnt   <= conv_load;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SEQ_CONV: begin
               if (cnt == '0) begin
                  state  <= SEQ_IDLE;
                  result <= sample_in;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_flag <= 1'b0;
      else if (finish)   done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
   end

endmodule

// File: rtl/cat_formatter.sv
module cat_formatter #(
   parameter int RES_W  = 10,
   parameter int BYTE_W = 8
) (
   input  logic [RES_W-1:0]  res,
   input  logic              left_just,
   output logic [BYTE_W-1:0] hi,
   output logic [BYTE_W-1:0] lo
);

   localparam int PAIR_W = 2 * BYTE_W;
   localparam int PAD_W  = PAIR_W - RES_W;

   if (RES_W > PAIR_W || RES_W < 1) begin : g_bad_res
      $error("cat_formatter: RES_W must fit in two bytes");
   end

   logic [PAIR_W-1:0] pair;

   if (PAD_W == 0) begin : g_full
      always_comb pair = res;
   end else begin : g_pad
      always_comb begin
         if (left_just) pair = {res, {PAD_W{1'b0}}};
         else           pair = {{PAD_W{1'b0}}, res};
      end
   end

   always_comb begin
      hi = pair[PAIR_W-1:BYTE_W];
      lo = pair[BYTE_W-1:0];
   end

endmodule

// File: rtl/cmp_adc_trigger.sv
module cmp_adc_trigger #(
   parameter int TMR_W            = 16,
   parameter int MODE_W           = 4,
   parameter logic [3:0] SEV_CODE = 4'b1011,
   parameter int ACQ_W            = 3,
   parameter int RES_W            = 10,
   parameter int BYTE_W           = 8,
   parameter int CONV_PERIODS     = 11,
   parameter int TAD_CYCLES       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tmr_tick,
   input  logic [MODE_W-1:0] cmp_mode,
   input  logic [TMR_W-1:0]  cmp_value,
   input  logic              adc_enable,
   input  logic [ACQ_W-1:0]  acq_code,
   input  logic              left_just,
   input  logic              sw_start,
   input  logic              done_clr,
   input  logic [RES_W-1:0]  sample_in,
   output logic [TMR_W-1:0]  timer_q,
   output logic              special_trig,
   output logic              busy,
   output logic              done_flag,
   output logic [BYTE_W-1:0] result_hi,
   output logic [BYTE_W-1:0] result_lo
);

   logic             start_req;
   logic [RES_W-1:0] result;

   cat_timer #(
      .TMR_W   (TMR_W),
      .MODE_W  (MODE_W),
      .SEV_CODE(SEV_CODE)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tmr_tick),
      .mode (cmp_mode),
      .cmp  (cmp_value),
      .count(timer_q),
      .match(special_trig)
   );

   always_comb start_req = special_trig | sw_start;

   cat_sequencer #(
      .ACQ_W       (ACQ_W),
      .RES_W       (RES_W),
      .CONV_PERIODS(CONV_PERIODS),
      .TAD_CYCLES  (TAD_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_req(start_req),
      .enable   (adc_enable),
      .acq_code (acq_code),
      .sample_in(sample_in),
      .done_clr (done_clr),
      .busy     (busy),
      .done_flag(done_flag),
      .result   (result)
   );

   cat_formatter #(
      .RES_W (RES_W),
      .BYTE_W(BYTE_W)
   ) u_fmt (
      .res      (result),
      .left_just(left_just),
      .hi       (result_hi),
      .lo       (result_lo)
   );

endmodule

// File: rtl/cmp_adc_trigger_chk.sv
module cmp_adc_trigger_chk #(
   parameter int TMR_W            = 16,
   parameter int MODE_W           = 4,
   parameter logic [3:0] SEV_CODE = 4'b1011,
   parameter int ACQ_W            = 3,
   parameter int RES_W            = 10,
   parameter int BYTE_W           = 8,
   parameter int CONV_PERIODS     = 11,
   parameter int TAD_CYCLES       = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tmr_tick,
   input logic [MODE_W-1:0] cmp_mode,
   input logic [TMR_W-1:0]  cmp_value,
   input logic              adc_enable,
   input logic [ACQ_W-1:0]  acq_code,
   input logic              left_just,
   input logic              sw_start,
   input logic              done_clr,
   input logic [RES_W-1:0]  sample_in,
   input logic [TMR_W-1:0]  timer_q,
   input logic              special_trig,
   input logic              busy,
   input logic              done_flag,
   input logic [BYTE_W-1:0] result_hi,
   input logic [BYTE_W-1:0] result_lo
);

   localparam int PAIR_W = 2 * BYTE_W;
   localparam int PAD_W  = PAIR_W - RES_W;

   logic [PAIR_W-1:0] pair;
   logic              hit;

   always_comb begin
      pair = {result_hi, result_lo};
      hit  = tmr_tick && (cmp_mode == SEV_CODE) && (timer_q == cmp_value);
   end

   a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (timer_q == '0));

   a_r2_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_tick && !hit) |=> (timer_q == TMR_W'($past(timer_q) + 1'b1)));

   a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_tick |=> $stable(timer_q));

   a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_enable && !busy) |=> !busy);

   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      (special_trig && adc_enable && !busy) |=> busy);

   a_r9_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);

   a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag);

   a_r12_right_pad: assert property (@(posedge clk) disable iff (!rst_n)
      !left_just |-> ((pair >> RES_W) == '0));

   if (PAD_W > 0) begin : g_left_chk
      a_r12_left_pad: assert property (@(posedge clk) disable iff (!rst_n)
         left_just |-> (pair[PAD_W-1:0] == '0));
   end

endmodule

bind cmp_adc_trigger cmp_adc_trigger_chk #(
   .TMR_W       (TMR_W),
   .MODE_W      (MODE_W),
   .SEV_CODE    (SEV_CODE),
   .ACQ_W       (ACQ_W),
   .RES_W       (RES_W),
   .BYTE_W      (BYTE_W),
   .CONV_PERIODS(CONV_PERIODS),
   .TAD_CYCLES  (TAD_CYCLES)
) u_chk (.*);

// File: tb/cmp_adc_trigger_test.sv
module cmp_adc_trigger_test;
   localparam int TAD  = 2;
   localparam int CONV = 11;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        tmr_tick = 1'b0;
   logic [3:0]  cmp_mode = 4'b0;
   logic [15:0] cmp_value = 16'd0;
   logic        adc_enable = 1'b0;
   logic [2:0]  acq_code = 3'd0;
   logic        left_just = 1'b0;
   logic        sw_start = 1'b0;
   logic        done_clr = 1'b0;
   logic [9:0]  sample_in = 10'd0;
   logic [15:0] timer_q;
   logic        special_trig, busy, done_flag;
   logic [7:0]  result_hi, result_lo;

   cmp_adc_trigger uut (.*);

   int          nvec = 0, nfail = 0;
   logic [15:0] m_t = 0;
   logic        m_busy = 0, m_done = 0;
   logic [9:0]  m_res = 0;
   int          m_cnt = 0;
   bit          ended = 0;

   function automatic int acq_map(input int c);
      return (c <= 4) ? 2 * c : 8 + 4 * (c - 4);
   endfunction

   function automatic logic [15:0] fmt(input logic [9:0] r, input logic lj);
      return lj ? {r, 6'b0} : {6'b0, r};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   endtask

   // one clock: check the pulse mid-cycle, advance model, compare registers
   task automatic step();
      logic m_match, was_busy, fin;
      #8;
      m_match = tmr_tick && cmp_mode == 4'b1011 && m_t == cmp_value;
      chk("R3 special_trig", special_trig, m_match);
      @(posedge clk); #2;
      was_busy = m_busy;
      fin = 0;
      if (m_busy) begin
         m_cnt--;
         if (m_cnt == 0) begin fin = 1; m_busy = 0; m_res = sample_in; end
      end
      if (fin) m_done = 1;
      else if (done_clr) m_done = 0;
      if ((m_match || sw_start) && adc_enable && !was_busy) begin
         m_busy = 1;
         m_cnt = (acq_map(int'(acq_code)) + CONV) * TAD;
      end
      if (m_match) m_t = 0;
      else if (tmr_tick) m_t = m_t + 1'b1;
      chk("R2/R3 timer", timer_q, m_t);
      chk("R5/R7/R8/R11 busy", busy, m_busy);
      chk("R9/R10 done", done_flag, m_done);
      chk("R9/R12 result", {result_hi, result_lo}, fmt(m_res, left_just));
   endtask

   task automatic do_reset();
      rst_n = 0; tmr_tick = 0; sw_start = 0; done_clr = 0;
      @(posedge clk); @(posedge clk); #2;
      m_t = 0; m_busy = 0; m_done = 0; m_res = 0; m_cnt = 0;
      rst_n = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL R9 watchdog actual=hung expected=completion");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd2718));
      do_reset();
      // R1 reset state
      chk("R1 timer", timer_q, 16'd0);
      chk("R1 busy", busy, 1'b0);
      chk("R1 done", done_flag, 1'b0);
      chk("R1 result", {result_hi, result_lo}, 16'd0);

      // R2 counting and holding
      cmp_mode = 4'b1011; cmp_value = 16'd5; adc_enable = 1; acq_code = 0;
      sample_in = 10'h2D5; tmr_tick = 1;
      repeat (3) step();
      chk("R2 count", timer_q, 16'd3);
      tmr_tick = 0; step();
      chk("R2 hold", timer_q, 16'd3);

      // R3 and R5: match restarts timer and starts conversion
      tmr_tick = 1;
      while (timer_q != 16'd5) step();
      step();
      chk("R3 timer cleared", timer_q, 16'd0);
      chk("R5 busy set", busy, 1'b1);
      // R7, R8: matches every 6 cycles during 22-cycle conversion
      n = 0;
      do begin step(); n++; end while (busy && n < 100);
      chk("R7/R8 busy length code0", n, 22);
      chk("R9 done set", done_flag, 1'b1);
      tmr_tick = 0;
      // R12 both justifications
      left_just = 0; #1;
      chk("R12 right hi", result_hi, 8'h02);
      chk("R12 right lo", result_lo, 8'hD5);
      left_just = 1; #1;
      chk("R12 left hi", result_hi, 8'hB5);
      chk("R12 left lo", result_lo, 8'h40);
      // R10 sticky, then clear
      repeat (3) step();
      chk("R10 done held", done_flag, 1'b1);
      done_clr = 1; step(); done_clr = 0;
      chk("R10 done cleared", done_flag, 1'b0);

      // R6: disabled converter ignores match, timer still clears
      adc_enable = 0; tmr_tick = 1;
      while (timer_q != 16'd5) step();
      step();
      chk("R6 timer cleared", timer_q, 16'd0);
      chk("R6 busy stays low", busy, 1'b0);
      tmr_tick = 0;

      // R11 software start, longest acquisition, set beats clear (R10)
      sw_start = 1; step(); sw_start = 0;
      chk("R11 disabled start ignored", busy, 1'b0);
      adc_enable = 1; acq_code = 3'd7; sample_in = 10'h155;
      sw_start = 1; step(); sw_start = 0;
      chk("R11 start", busy, 1'b1);
      sw_start = 1; step(); sw_start = 0;
      n = 1; done_clr = 1;
      do begin step(); n++; end while (busy && n < 200);
      done_clr = 0;
      chk("R8 busy length code7", n, 62);
      chk("R10 set beats clear", done_flag, 1'b1);

      // R4: other mode lets timer pass the compare value
      cmp_mode = 4'b0011; tmr_tick = 1;
      while (timer_q != 16'd5) step();
      step();
      chk("R4 timer passes", timer_q, 16'd6);
      chk("R4 no conversion", busy, 1'b0);
      do_reset();

      // constrained random phase
      cmp_mode = 4'b1011; cmp_value = 16'd20;
      for (int i = 0; i < 6000; i++) begin
         if (m_t < 16'd8 && ($urandom % 50) == 0) cmp_value = 16'(8 + $urandom % 73);
         tmr_tick   = ($urandom % 4) != 0;
         cmp_mode   = (m_t + 1 < cmp_value && ($urandom % 6) == 0) ?
                      4'($urandom) : 4'b1011;
         adc_enable = ($urandom % 7) != 0;
         acq_code   = 3'($urandom);
         sw_start   = ($urandom % 30) == 0;
         done_clr   = ($urandom % 20) == 0;
         sample_in  = 10'($urandom);
         left_just  = 1'($urandom);
         step();
      end
      finish_run();
   end
endmodule